// File: doc/BRIEF.md
# Two-Dimensional Block Parity Encoder and Checker

This block protects groups of characters with parity in two directions. On the send path it accepts data characters over a valid/ready stream and appends a row parity bit to each one. Once a block of characters has been accepted, it emits one extra block check character. Each bit of that character is the parity of one bit column across the whole block.

The receive path takes framed characters. It checks each row as it arrives and passes the data bits on together with a per-character row error flag. It also accumulates the column parities. When the check character arrives, it reports a map of failing rows, a vector of failing columns and a summary flag for the block. A single flipped bit shows up as one row error and one column error. Two flips inside one character escape the row check, but they still raise exactly two column flags.

Both even and odd parity are supported through one static select input, and that select governs row and column parity on both paths. The number of characters per block is a parameter. The receiver finds block boundaries by counting characters from reset, so the sender and the receiver must agree on that parameter.

Top module: `xy_parity_codec`

## Requirements
- R1: Each data character leaves the send path as 8 bits: data in bits 6:0 and the row parity bit in bit 7. Bit 7 makes the count of ones over all 8 bits even when odd_sel=0 and odd when odd_sel=1.
- R2: After every BLOCK_LEN (default 8) accepted characters, the send path emits one check character marked by tx_out_check=1. Its bit j makes the count of ones in column j, taken over the block's encoded characters plus the check bit, even or odd according to odd_sel. The next accepted character starts a fresh column accumulation.
- R3: In the cycle after the last character of a block is accepted, tx_in_ready is 0. It stays 0 until the check character has been loaded into the output.
- R4: While tx_out_valid=1 and tx_out_ready=0, tx_out_data and tx_out_check stay unchanged. Every accepted character and every check character appears exactly once, in order.
- R5: Each received data character (rx_in_valid=1) produces, one cycle later, a one-cycle rx_char_valid pulse. With it, rx_char_data holds bits 6:0, and rx_row_err=1 exactly when the 8-bit row breaks the selected parity sense. Cycles with rx_in_valid=0 produce no pulse.
- R6: The receive path takes the character after every BLOCK_LEN data characters as the check character. Such a character gives no rx_char_valid. One cycle later it gives a one-cycle rx_blk_valid pulse with three outputs: rx_col_err bit j set when column j fails; rx_row_map bit i set when the i-th character of the block (0 = first) failed its row check; and rx_blk_err set when any row or column failed.
- R7: One flipped bit in a data character flags that character's row and exactly the column of the flipped bit, including column 7 when the parity bit itself flips. One flipped bit in the check character flags only its column.
- R8: Two flipped bits in one character give no row error and exactly the two affected column flags.
- R9: With odd_sel=1, both paths use odd parity for rows and columns. A clean odd-parity block raises no error.
- R10: After reset, tx_out_valid=0, tx_in_ready=1, rx_char_valid=0, rx_blk_valid=0, and both paths start at the first character of a block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| odd_sel | input | 1 | Parity sense: 0 even, 1 odd |
| tx_in_valid | input | 1 | Send path data character offered |
| tx_in_ready | output | 1 | Send path can accept a character |
| tx_in_data | input | DATA_W (7) | Data character to encode |
| tx_out_valid | output | 1 | Encoded character available |
| tx_out_ready | input | 1 | Downstream takes the encoded character |
| tx_out_data | output | DATA_W+1 (8) | Encoded character or check character |
| tx_out_check | output | 1 | Marks tx_out_data as the block check character |
| rx_in_valid | input | 1 | Received character present |
| rx_in_data | input | DATA_W+1 (8) | Received character, parity in the top bit |
| rx_char_valid | output | 1 | Pulse: checked data character available |
| rx_char_data | output | DATA_W (7) | Data bits of the checked character |
| rx_row_err | output | 1 | Row parity failure for this character |
| rx_blk_valid | output | 1 | Pulse: block report available |
| rx_row_map | output | BLOCK_LEN (8) | Failing rows of the block |
| rx_col_err | output | DATA_W+1 (8) | Failing columns of the block |
| rx_blk_err | output | 1 | Any row or column failed |

## Verification
The assertions assume that odd_sel holds steady while a block is in flight on either path, and that the received stream is aligned to a block boundary from reset. The row-sense checks on both paths compare against the present or previous value of that select. The stimulus therefore changes odd_sel only after the send path has been drained and the receive path sits between blocks. It also always feeds the receive path whole blocks. Error injection is done with XOR masks on encoded characters, so the expected row and column flags follow from the mask bits alone.

// File: rtl/xyp_pkg.sv
package xyp_pkg;

   localparam int unsigned DEF_DATA_W    = 7;
   localparam int unsigned DEF_BLOCK_LEN = 8;

   typedef enum logic {
      SENSE_EVEN = 1'b0,
      SENSE_ODD  = 1'b1
   } par_sense_e;

   // Bits needed for a counter that reaches n inclusive.
   function automatic int cnt_bits(input int n);
      return (n < 1) ? 1 : $clog2(n + 1);
   endfunction

endpackage

// File: rtl/xyp_tx.sv
module xyp_tx
   import xyp_pkg::*;
#(
   parameter int DATA_W    = DEF_DATA_W,
   parameter int BLOCK_LEN = DEF_BLOCK_LEN
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              odd_sel,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [DATA_W-1:0] in_data,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [DATA_W:0]   out_data,
   output logic              out_check
);

   localparam int CW    = DATA_W + 1;
   localparam int CNT_W = cnt_bits(BLOCK_LEN);
   localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(BLOCK_LEN - 1);

   logic [CNT_W-1:0] cnt_q;
   logic [CW-1:0]    acc_q;
   logic [CW-1:0]    out_q;
   logic             vld_q;
   logic             chk_q;
   logic             pend_q;
   logic             out_free;
   logic             in_fire;
   logic [CW-1:0]    enc;

   assign out_free = !vld_q || out_ready;
   assign in_ready = out_free && !pend_q;
   assign in_fire  = in_valid && in_ready;
   assign enc      = {(^in_data) ^ odd_sel, in_data};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         acc_q  <= '0;
         out_q  <= '0;
         vld_q  <= 1'b0;
         chk_q  <= 1'b0;
         pend_q <= 1'b0;
      end else if (in_fire) begin
         out_q <= enc;
         chk_q <= 1'b0;
         vld_q <= 1'b1;
         acc_q <= (cnt_q == '0) ? enc : (acc_q ^ enc);
         if (cnt_q == LAST_IDX) begin
            cnt_q  <= '0;
            pend_q <= 1'b1;
         end else begin
            cnt_q <= cnt_q + CNT_W'(1);
         end
      end else if (pend_q && out_free) begin
         out_q  <= acc_q ^ {CW{odd_sel}};
         chk_q  <= 1'b1;
         vld_q  <= 1'b1;
         pend_q <= 1'b0;
      end else if (out_ready) begin
         vld_q <= 1'b0;
      end
   end

   assign out_valid = vld_q;
   assign out_data  = out_q;
   assign out_check = chk_q;

   AST_ROW_SENSE: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_check) |-> ((^out_data) == odd_sel)); // R1
   AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_check))); // R4

endmodule

// File: rtl/xyp_rx.sv
module xyp_rx
   import xyp_pkg::*;
#(
   parameter int DATA_W    = DEF_DATA_W,
   parameter int BLOCK_LEN = DEF_BLOCK_LEN
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 odd_sel,
   input  logic                 in_valid,
   input  logic [DATA_W:0]      in_data,
   output logic                 char_valid,
   output logic [DATA_W-1:0]    char_data,
   output logic                 row_err,
   output logic                 blk_valid,
   output logic [BLOCK_LEN-1:0] row_map,
   output logic [DATA_W:0]      col_err,
   output logic                 blk_err
);

   localparam int CW    = DATA_W + 1;
   localparam int CNT_W = cnt_bits(BLOCK_LEN);
   localparam logic [CNT_W-1:0] CHK_IDX = CNT_W'(BLOCK_LEN);

   logic [CNT_W-1:0]     cnt_q;
   logic [CW-1:0]        acc_q;
   logic [BLOCK_LEN-1:0] map_q;
   logic [BLOCK_LEN-1:0] map_nxt;
   logic [CW-1:0]        col_bad;
   logic                 row_bad;
   logic                 is_chk;

   logic                 cv_q, re_q, bv_q, be_q;
   logic [DATA_W-1:0]    cd_q;
   logic [BLOCK_LEN-1:0] mo_q;
   logic [CW-1:0]        ce_q;

   assign is_chk  = (cnt_q == CHK_IDX);
   assign row_bad = (^in_data) ^ odd_sel;

   // One comparator per column: accumulated parity, check bit and sense.
   for (genvar j = 0; j < CW; j++) begin : g_col
      assign col_bad[j] = acc_q[j] ^ in_data[j] ^ odd_sel;
   end

   always_comb begin
      for (int i = 0; i < BLOCK_LEN; i++) begin
         if (cnt_q == CNT_W'(i))
            map_nxt[i] = row_bad;
         else
            map_nxt[i] = (cnt_q == '0) ? 1'b0 : map_q[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         acc_q <= '0;
         map_q <= '0;
         cv_q  <= 1'b0;
         re_q  <= 1'b0;
         bv_q  <= 1'b0;
         be_q  <= 1'b0;
         cd_q  <= '0;
         mo_q  <= '0;
         ce_q  <= '0;
      end else begin
         cv_q <= 1'b0;
         re_q <= 1'b0;
         bv_q <= 1'b0;
         if (in_valid) begin
            if (!is_chk) begin
               cv_q  <= 1'b1;
               cd_q  <= in_data[DATA_W-1:0];
               re_q  <= row_bad;
               acc_q <= (cnt_q == '0) ? in_data : (acc_q ^ in_data);
               map_q <= map_nxt;
               cnt_q <= cnt_q + CNT_W'(1);
            end else begin
               bv_q  <= 1'b1;
               ce_q  <= col_bad;
               mo_q  <= map_q;
               be_q  <= (|map_q) || (|col_bad);
               cnt_q <= '0;
            end
         end
      end
   end

   assign char_valid = cv_q;
   assign char_data  = cd_q;
   assign row_err    = re_q;
   assign blk_valid  = bv_q;
   assign row_map    = mo_q;
   assign col_err    = ce_q;
   assign blk_err    = be_q;

   AST_ROW_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      char_valid |-> (row_err == ((^$past(in_data)) != $past(odd_sel)))); // R5
   AST_ROW_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !char_valid |-> !row_err); // R5
   AST_BLK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      blk_valid |=> !blk_valid); // R6
   AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
      !(char_valid && blk_valid)); // R6

endmodule

// File: rtl/xy_parity_codec.sv
module xy_parity_codec
   import xyp_pkg::*;
#(
   parameter int DATA_W    = DEF_DATA_W,
   parameter int BLOCK_LEN = DEF_BLOCK_LEN
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 odd_sel,
   input  logic                 tx_in_valid,
   output logic                 tx_in_ready,
   input  logic [DATA_W-1:0]    tx_in_data,
   output logic                 tx_out_valid,
   input  logic                 tx_out_ready,
   output logic [DATA_W:0]      tx_out_data,
   output logic                 tx_out_check,
   input  logic                 rx_in_valid,
   input  logic [DATA_W:0]      rx_in_data,
   output logic                 rx_char_valid,
   output logic [DATA_W-1:0]    rx_char_data,
   output logic                 rx_row_err,
   output logic                 rx_blk_valid,
   output logic [BLOCK_LEN-1:0] rx_row_map,
   output logic [DATA_W:0]      rx_col_err,
   output logic                 rx_blk_err
);

   if (DATA_W < 1 || DATA_W > 63) begin : g_bad_width
      $error("xy_parity_codec: DATA_W must be 1..63");
   end
   if (BLOCK_LEN < 2 || BLOCK_LEN > 1024) begin : g_bad_len
      $error("xy_parity_codec: BLOCK_LEN must be 2..1024");
   end

   xyp_tx #(.DATA_W(DATA_W), .BLOCK_LEN(BLOCK_LEN)) u_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .odd_sel   (odd_sel),
      .in_valid  (tx_in_valid),
      .in_ready  (tx_in_ready),
      .in_data   (tx_in_data),
      .out_valid (tx_out_valid),
      .out_ready (tx_out_ready),
      .out_data  (tx_out_data),
      .out_check (tx_out_check)
   );

   xyp_rx #(.DATA_W(DATA_W), .BLOCK_LEN(BLOCK_LEN)) u_rx (
      .clk        (clk),
      .rst_n      (rst_n),
      .odd_sel    (odd_sel),
      .in_valid   (rx_in_valid),
      .in_data    (rx_in_data),
      .char_valid (rx_char_valid),
      .char_data  (rx_char_data),
      .row_err    (rx_row_err),
      .blk_valid  (rx_blk_valid),
      .row_map    (rx_row_map),
      .col_err    (rx_col_err),
      .blk_err    (rx_blk_err)
   );

endmodule

// File: tb/xy_parity_codec_tb.sv
module xy_parity_codec_tb;

   localparam int CLK_PERIOD = 10;
   localparam int DW = 7;
   localparam int BL = 8;
   localparam int CW = DW + 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          odd_sel = 1'b0;
   logic          tx_in_valid = 1'b0;
   logic          tx_in_ready;
   logic [DW-1:0] tx_in_data = '0;
   logic          tx_out_valid;
   logic          tx_out_ready = 1'b0;
   logic [CW-1:0] tx_out_data;
   logic          tx_out_check;
   logic          rx_in_valid = 1'b0;
   logic [CW-1:0] rx_in_data = '0;
   logic          rx_char_valid;
   logic [DW-1:0] rx_char_data;
   logic          rx_row_err;
   logic          rx_blk_valid;
   logic [BL-1:0] rx_row_map;
   logic [CW-1:0] rx_col_err;
   logic          rx_blk_err;

   int n_chk = 0;
   int n_fail = 0;

   xy_parity_codec #(.DATA_W(DW), .BLOCK_LEN(BL)) u_dut (
      .clk(clk), .rst_n(rst_n), .odd_sel(odd_sel),
      .tx_in_valid(tx_in_valid), .tx_in_ready(tx_in_ready), .tx_in_data(tx_in_data),
      .tx_out_valid(tx_out_valid), .tx_out_ready(tx_out_ready),
      .tx_out_data(tx_out_data), .tx_out_check(tx_out_check),
      .rx_in_valid(rx_in_valid), .rx_in_data(rx_in_data),
      .rx_char_valid(rx_char_valid), .rx_char_data(rx_char_data), .rx_row_err(rx_row_err),
      .rx_blk_valid(rx_blk_valid), .rx_row_map(rx_row_map),
      .rx_col_err(rx_col_err), .rx_blk_err(rx_blk_err)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
      $finish;
   end

   // Reference encoding, written from the requirement text.
   function automatic logic row_bit(input logic [DW-1:0] d);
      return (($countones(d) % 2) == 1) ^ odd_sel;
   endfunction

   function automatic logic [CW-1:0] col_chk(input logic [CW-1:0] rows[$]);
      logic [CW-1:0] r;
      for (int j = 0; j < CW; j++) begin
         int ones = 0;
         foreach (rows[k]) ones += int'(rows[k][j]);
         r[j] = ((ones % 2) == 1) ^ odd_sel;
      end
      return r;
   endfunction

   // ---------------- send path model ----------------
   logic [CW:0]   txq[$];
   logic [CW-1:0] tx_blk[$];
   bit            stall_exp = 0;

   task automatic tx_cycle(input bit v, input logic [DW-1:0] d, input bit ordy);
      logic [CW:0]   e;
      logic [CW-1:0] ec;
      string         tag;
      @(negedge clk);
      chk("R4", "tx_out_valid vs pending items", 32'(tx_out_valid), 32'(txq.size() != 0));
      tx_in_valid  = v;
      tx_in_data   = d;
      tx_out_ready = ordy;
      #1;
      if (stall_exp) begin
         chk("R3", "tx_in_ready after last char", 32'(tx_in_ready), 32'(0));
         stall_exp = 0;
      end
      if (tx_out_valid && tx_out_ready) begin
         if (txq.size() == 0) begin
            chk("R4", "unexpected output", 32'(1), 32'(0));
         end else begin
            e = txq.pop_front();
            tag = odd_sel ? "R9" : (e[CW] ? "R2" : "R1");
            chk(tag, "tx_out_data", 32'(tx_out_data), 32'(e[CW-1:0]));
            chk("R2", "tx_out_check", 32'(tx_out_check), 32'(e[CW]));
         end
      end
      if (v && tx_in_ready) begin
         ec = {row_bit(d), d};
         txq.push_back({1'b0, ec});
         tx_blk.push_back(ec);
         if (tx_blk.size() == BL) begin
            txq.push_back({1'b1, col_chk(tx_blk)});
            tx_blk.delete();
            stall_exp = 1;
         end
      end
   endtask

   task automatic tx_drain();
      repeat (6) tx_cycle(1'b0, '0, 1'b1);
      chk("R4", "all items delivered", 32'(txq.size()), 32'(0));
   endtask

   // ---------------- receive path model ----------------
   logic [DW-1:0] dat [BL];
   logic [CW-1:0] msk [BL];
   logic [CW-1:0] cmsk;
   string         rx_tag = "R6";
   bit            e_cv = 0, e_re = 0, e_bv = 0, e_be = 0;
   logic [DW-1:0] e_cd;
   logic [BL-1:0] e_map;
   logic [CW-1:0] e_col;

   task automatic rx_step(input bit v, input logic [CW-1:0] d);
      @(negedge clk);
      chk("R5", "rx_char_valid", 32'(rx_char_valid), 32'(e_cv));
      if (e_cv) begin
         chk("R5", "rx_char_data", 32'(rx_char_data), 32'(e_cd));
         chk(rx_tag, "rx_row_err", 32'(rx_row_err), 32'(e_re));
      end
      chk("R6", "rx_blk_valid", 32'(rx_blk_valid), 32'(e_bv));
      if (e_bv) begin
         chk(rx_tag, "rx_row_map", 32'(rx_row_map), 32'(e_map));
         chk(rx_tag, "rx_col_err", 32'(rx_col_err), 32'(e_col));
         chk(rx_tag, "rx_blk_err", 32'(rx_blk_err), 32'(e_be));
      end
      e_cv = 0;
      e_bv = 0;
      rx_in_valid = v;
      rx_in_data  = d;
   endtask

   task automatic rx_block(input int gap);
      logic [CW-1:0] enc[$];
      logic [CW-1:0] colx;
      logic [BL-1:0] map;
      for (int i = 0; i < BL; i++) enc.push_back({row_bit(dat[i]), dat[i]});
      colx = cmsk;
      map  = '0;
      for (int i = 0; i < BL; i++) begin
         rx_step(1'b1, enc[i] ^ msk[i]);
         e_cv   = 1;
         e_cd   = dat[i] ^ msk[i][DW-1:0];
         e_re   = ($countones(msk[i]) % 2) == 1;
         map[i] = e_re;
         colx   = colx ^ msk[i];
         repeat (gap) rx_step(1'b0, '0);
      end
      rx_step(1'b1, col_chk(enc) ^ cmsk);
      e_bv  = 1;
      e_map = map;
      e_col = colx;
      e_be  = (|map) || (|colx);
      rx_step(1'b0, '0);
   endtask

   task automatic rx_clear_masks(input int seed);
      for (int i = 0; i < BL; i++) begin
         dat[i] = DW'(i * 23 + seed);
         msk[i] = '0;
      end
      cmsk = '0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10", "tx_out_valid after reset", 32'(tx_out_valid), 32'(0));
      chk("R10", "tx_in_ready after reset", 32'(tx_in_ready), 32'(1));
      chk("R10", "rx_char_valid after reset", 32'(rx_char_valid), 32'(0));
      chk("R10", "rx_blk_valid after reset", 32'(rx_blk_valid), 32'(0));

      // Send path: full rate, even parity.
      odd_sel = 1'b0;
      for (int i = 0; i < BL; i++) tx_cycle(1'b1, DW'(i * 13 + 5), 1'b1);
      // Second block with gaps and back-pressure; fresh accumulation.
      for (int i = 0; i < 3 * BL + 10; i++)
         tx_cycle((i % 4) != 1, DW'(i * 37 + 9), (i % 3) != 0);
      tx_drain();
      // Finish any partial block so the next phase starts at a boundary.
      while (tx_blk.size() != 0) tx_cycle(1'b1, 7'h55, 1'b1);
      tx_drain();
      // Odd parity, slow consumer.
      odd_sel = 1'b1;
      for (int i = 0; i < 2 * BL; i++) tx_cycle(1'b1, DW'(i * 29 + 1), (i % 2) == 0);
      tx_drain();
      while (tx_blk.size() != 0) tx_cycle(1'b1, 7'h2a, 1'b1);
      tx_drain();

      // Receive path, even parity.
      odd_sel = 1'b0;
      rx_tag = "R6";
      rx_clear_masks(4);
      rx_block(0);
      rx_tag = "R7";
      rx_clear_masks(11);
      msk[3] = 8'h04;
      rx_block(1);
      rx_clear_masks(2);
      msk[0] = 8'h80;
      rx_block(0);
      rx_clear_masks(7);
      cmsk = 8'h10;
      rx_block(0);
      rx_tag = "R8";
      rx_clear_masks(19);
      msk[5] = 8'h11;
      rx_block(2);
      rx_clear_masks(3);
      msk[1] = 8'h42;
      msk[6] = 8'h01;
      rx_block(0);

      // Receive path, odd parity.
      odd_sel = 1'b1;
      rx_tag = "R9";
      rx_clear_masks(31);
      rx_block(0);
      rx_clear_masks(8);
      msk[7] = 8'h80;
      msk[2] = 8'h0c;
      rx_block(1);

      summary();
      $finish;
   end

endmodule